// File: doc/BRIEF.md
# Sectored NOR Flash Command Controller

This block is the control core of a small sectored NOR flash memory, modelled so that it can be synthesized. A host drives an asynchronous-style bus made of active-low chip enable, write enable and output enable, a word address, 16-bit write data, a byte/word mode select with a byte-lane bit, and an active-low reset pin. Every bus input is sampled on the system clock. The array lives in an on-chip RAM and is organised as seven sectors of unequal size. A parameter selects whether the small sectors sit at the low end of the address space (bottom boot) or at the high end (top boot).

Writes form unlock-prefixed command sequences. These sequences start automated operations: a word or byte program, a sector erase and a chip erase. Cycle-count timers stand in for pulse timing. While an operation runs, reads return a status word rather than array data, and the ready output stays low. An erase can be suspended, which lets the host read the sectors that are not being erased, and can then be resumed. Per-sector protect inputs block program and erase. The reset pin aborts whatever operation is running.

Top module: `flash_ctrl`

## Requirements
- R1: After reset, `ready` is 1 and every word of the array reads 16'hFFFF in word mode.
- R2: A bus write is taken exactly once for each stretch of cycles in which `ce_n`=0, `we_n`=0 and `oe_n`=1. `ready` only falls in the cycle after such a write has been sampled.
- R3: Programming stores old AND new. Programming never changes a 0 back to 1.
- R4: A sector erase first writes zeros through the whole sector, then writes 16'hFFFF through it. Words outside the sector keep their values.
- R5: A program or sector erase aimed at a protected sector (`prot[s]`=1) is ignored, and `ready` stays 1. A chip erase erases every unprotected sector and leaves protected ones untouched.
- R6: While an operation is active, a read returns the status word {8'h00, DQ7, DQ6, 6'b0}. DQ7 is the complement of bit 7 of the data being written, which makes it 0 during an erase. DQ6 inverts on every status read. DQ6 reads 1 on the first status read after reset. `ready` is 0 for the whole operation, and the array is written only while `ready` is 0.
- R7: When an operation finishes, the controller returns to read mode by itself with `ready`=1.
- R8: Driving `rst_pin_n` low aborts any operation, returns to read mode and sets `ready`=1 on the next clock. After that, new commands work.
- R9: A write of 8'hB0 during an erase suspends it, and `ready` goes to 1. Reads of other sectors then return array data, while reads of the erasing sector return status with DQ7=0. A write of 8'h30 resumes the erase, which then completes.
- R10: The sequence AA@555, 55@2AA, 90@555 enters ID mode. In ID mode a read with `addr[0]`=0 returns 16'h0052 and a read with `addr[0]`=1 returns 16'h0057 (bottom boot) or 16'h0051 (top boot). A write of F0 returns the controller to array reads.
- R11: Commands use unlock cycles AA@555 then 55@2AA, with addresses compared on the low AW bits. The command byte that follows is A0 for program (the next write carries address and data) or 80 for erase setup (then AA@555, 55@2AA, and either 10@555 for chip erase or 30 at any address in the target sector). Any cycle that does not fit the sequence returns the decoder to read mode without starting anything.
- R12: With `byte_mode`=1, `lane` selects the high (1) or low (0) byte. A read returns that byte in dout[7:0] with dout[15:8]=0. A program changes only the selected byte.
- R13: In bottom boot, sector sizes in UNIT_W-word units, from the lowest address up, are 2,1,1,4,8,8,8. Top boot mirrors this order. With UNIT_W=4, sector 3 covers words 16..31.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| rst_pin_n | input | 1 | Active-low reset pin, aborts operations |
| ce_n | input | 1 | Chip enable, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| byte_mode | input | 1 | 1 = byte access, 0 = word access |
| lane | input | 1 | Byte lane select in byte mode |
| addr | input | AW | Word address |
| din | input | 16 | Write data / command byte in din[7:0] |
| prot | input | 7 | Per-sector protect, bit s protects sector s |
| dout | output | 16 | Read data, status or ID code |
| dout_en | output | 1 | dout is valid (a read was sampled) |
| ready | output | 1 | 1 = idle or suspended, 0 = busy |

## Verification
The bench goes after the sector edges: it programs words just outside the erased sector and checks them afterwards. An erase that used the wrong sector table would wipe or miss those words. Repeated programs of the same word show whether bits can return to 1, which a plain overwrite would allow. A broken unlock sequence, and commands aimed at protected sectors, must leave both `ready` and the data alone, and a decoder that does not drop back to idle would start a program. Suspend, the reset-pin abort and chip erase with one protected sector cover the cases where a wrong design would keep writing during suspend, stay busy after the abort, or erase a protected sector.

// File: rtl/flc_pkg.sv
package flc_pkg;
  localparam int NSEC        = 7;
  localparam int TOTAL_UNITS = 32;

  typedef enum logic [1:0] {E_IDLE, E_PROG, E_ERASE, E_SUSP} eng_t;
  typedef enum logic [2:0] {C_IDLE, C_U1, C_U2, C_PRG, C_E1, C_E2, C_E3} cmd_t;

  // sector size in units; top boot mirrors the bottom-boot order
  function automatic int units_of(input bit top, input int s);
    int k;
    k = top ? (NSEC - 1 - s) : s;
    case (k)
      0:       return 2;
      1, 2:    return 1;
      3:       return 4;
      default: return 8;
    endcase
  endfunction

  function automatic int base_units(input bit top, input int s);
    int acc;
    acc = 0;
    for (int i = 0; i < NSEC; i++)
      if (i < s) acc += units_of(top, i);
    return acc;
  endfunction

  function automatic logic [2:0] sec_of(input bit top, input int u);
    logic [2:0] r;
    r = '0;
    for (int i = 0; i < NSEC; i++)
      if (u >= base_units(top, i)) r = 3'(i);
    return r;
  endfunction

  // bit 3 set means no unprotected sector at or above 'from'
  function automatic logic [3:0] first_open(input logic [NSEC-1:0] prot, input int from);
    logic [3:0] r;
    r = 4'h8;
    for (int i = NSEC - 1; i >= 0; i--)
      if (i >= from && !prot[i]) r = {1'b0, 3'(i)};
    return r;
  endfunction
endpackage

// File: rtl/flc_ram.sv
module flc_ram #(
  parameter int AW = 7,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 2 ** AW;
  logic [DW-1:0] mem [DEPTH];

  initial begin
    for (int i = 0; i < DEPTH; i++) mem[i] = '1;
  end

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/flc_cmd.sv
module flc_cmd import flc_pkg::*; #(
  parameter int AW = 7
) (
  input  logic          clk,
  input  logic          clr,
  input  logic          en,
  input  logic          wr_pulse,
  input  logic [AW-1:0] addr,
  input  logic [7:0]    d,
  output logic          req_prog,
  output logic          req_serase,
  output logic          req_cerase,
  output logic          id_mode
);
  localparam logic [10:0] ADR_A = 11'h555;
  localparam logic [10:0] ADR_B = 11'h2AA;
  cmd_t st;
  logic at_a, at_b;

  always_comb begin
    at_a       = (addr == ADR_A[AW-1:0]);
    at_b       = (addr == ADR_B[AW-1:0]);
    req_prog   = wr_pulse && en && st == C_PRG;
    req_serase = wr_pulse && en && st == C_E3 && d == 8'h30;
    req_cerase = wr_pulse && en && st == C_E3 && d == 8'h10 && at_a;
  end

  always_ff @(posedge clk) begin
    if (clr) begin
      st      <= C_IDLE;
      id_mode <= 1'b0;
    end else if (wr_pulse) begin
      if (d == 8'hF0 && st != C_PRG) begin
        st      <= C_IDLE;
        id_mode <= 1'b0;
      end else if (!en) begin
        st <= C_IDLE;
      end else begin
        case (st)
          C_IDLE: st <= (at_a && d == 8'hAA) ? C_U1 : C_IDLE;
          C_U1:   st <= (at_b && d == 8'h55) ? C_U2 : C_IDLE;
          C_U2: begin
            st <= C_IDLE;
            if (at_a && d == 8'hA0) st <= C_PRG;
            if (at_a && d == 8'h80) st <= C_E1;
            if (at_a && d == 8'h90) id_mode <= 1'b1;
          end
          C_E1:   st <= (at_a && d == 8'hAA) ? C_E2 : C_IDLE;
          C_E2:   st <= (at_b && d == 8'h55) ? C_E3 : C_IDLE;
          default: st <= C_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/flc_engine.sv
module flc_engine import flc_pkg::*; #(
  parameter bit TOP_BOOT = 1'b0,
  parameter int UNIT_W   = 4,
  parameter int AW       = 7,
  parameter int PROG_CYC = 16,
  parameter int STEP_CYC = 4
) (
  input  logic            clk,
  input  logic            clr,
  input  logic            wr_pulse,
  input  logic [7:0]      din8,
  input  logic            req_prog,
  input  logic            req_serase,
  input  logic            req_cerase,
  input  logic [AW-1:0]   req_addr,
  input  logic [15:0]     req_word,
  input  logic [NSEC-1:0] prot,
  output logic            ready,
  output logic            prog_on,
  output logic            erase_on,
  output logic            susp_on,
  output logic            pol7,
  output logic [2:0]      cur_sec,
  output logic [AW-1:0]   op_addr,
  output logic            mem_we,
  output logic [15:0]     mem_wdata,
  input  logic [15:0]     mem_rdata
);
  localparam int MAXC = (PROG_CYC > STEP_CYC) ? PROG_CYC : STEP_CYC;
  localparam int CW   = $clog2(MAXC) + 1;

  eng_t          st;
  logic          ph, chip;
  logic [CW-1:0] cnt;
  logic [15:0]   op_data;
  logic [2:0]    req_sec;
  logic [3:0]    first_s, next_s;
  logic [AW-1:0] sec_last;
  logic          sus_hit, res_hit;

  function automatic logic [AW-1:0] base_addr(input logic [2:0] s);
    return AW'(base_units(TOP_BOOT, int'(s)) * UNIT_W);
  endfunction

  always_comb begin
    req_sec  = sec_of(TOP_BOOT, int'(req_addr) / UNIT_W);
    first_s  = first_open(prot, 0);
    next_s   = first_open(prot, int'(cur_sec) + 1);
    sec_last = AW'((base_units(TOP_BOOT, int'(cur_sec)) + units_of(TOP_BOOT, int'(cur_sec))) * UNIT_W - 1);
    sus_hit  = wr_pulse && din8 == 8'hB0;
    res_hit  = wr_pulse && din8 == 8'h30;
    prog_on  = (st == E_PROG);
    erase_on = (st == E_ERASE);
    susp_on  = (st == E_SUSP);
    mem_we   = (st == E_PROG && cnt == '0) || (st == E_ERASE && cnt == '0 && !sus_hit);
    mem_wdata = (st == E_PROG) ? (mem_rdata & op_data) : {16{ph}};
  end

  always_ff @(posedge clk) begin
    if (clr) begin
      st <= E_IDLE; ready <= 1'b1; ph <= 1'b0; chip <= 1'b0; cnt <= '0;
      op_addr <= '0; op_data <= '1; pol7 <= 1'b0; cur_sec <= '0;
    end else begin
      case (st)
        E_IDLE: begin
          if (req_prog && !prot[req_sec]) begin
            st <= E_PROG; ready <= 1'b0; op_addr <= req_addr;
            op_data <= req_word; pol7 <= req_word[7]; cnt <= CW'(PROG_CYC - 1);
          end else if (req_serase && !prot[req_sec]) begin
            st <= E_ERASE; ready <= 1'b0; cur_sec <= req_sec; op_addr <= base_addr(req_sec);
            chip <= 1'b0; ph <= 1'b0; pol7 <= 1'b1; cnt <= CW'(STEP_CYC - 1);
          end else if (req_cerase && !first_s[3]) begin
            st <= E_ERASE; ready <= 1'b0; cur_sec <= first_s[2:0]; op_addr <= base_addr(first_s[2:0]);
            chip <= 1'b1; ph <= 1'b0; pol7 <= 1'b1; cnt <= CW'(STEP_CYC - 1);
          end
        end
        E_PROG: begin
          if (cnt == '0) begin
            st <= E_IDLE; ready <= 1'b1;
          end else cnt <= cnt - 1'b1;
        end
        E_ERASE: begin
          if (sus_hit) begin
            st <= E_SUSP; ready <= 1'b1;
          end else if (cnt == '0) begin
            cnt <= CW'(STEP_CYC - 1);
            if (op_addr != sec_last) op_addr <= op_addr + 1'b1;
            else if (!ph) begin
              ph <= 1'b1; op_addr <= base_addr(cur_sec);
            end else if (chip && !next_s[3]) begin
              cur_sec <= next_s[2:0]; op_addr <= base_addr(next_s[2:0]); ph <= 1'b0;
            end else begin
              st <= E_IDLE; ready <= 1'b1;
            end
          end else cnt <= cnt - 1'b1;
        end
        E_SUSP: begin
          if (res_hit) begin
            st <= E_ERASE; ready <= 1'b0; cnt <= CW'(STEP_CYC - 1);
          end
        end
        default: st <= E_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/flash_ctrl.sv
module flash_ctrl import flc_pkg::*; #(
  parameter bit         TOP_BOOT = 1'b0,
  parameter int         UNIT_W   = 4,
  parameter int         PROG_CYC = 16,  // at least 2: program reads the old word first
  parameter int         STEP_CYC = 4,
  parameter logic [7:0] MFR_CODE = 8'h52,
  parameter int         AW       = $clog2(TOTAL_UNITS * UNIT_W)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            rst_pin_n,
  input  logic            ce_n,
  input  logic            we_n,
  input  logic            oe_n,
  input  logic            byte_mode,
  input  logic            lane,
  input  logic [AW-1:0]   addr,
  input  logic [15:0]     din,
  input  logic [NSEC-1:0] prot,
  output logic [15:0]     dout,
  output logic            dout_en,
  output logic            ready
);
  localparam logic [7:0] DEV_CODE = TOP_BOOT ? 8'h51 : 8'h57;

  logic clr, wr_cond, rd_cond, wr_prev, rd_prev, wr_pulse;
  logic req_prog, req_serase, req_cerase, id_mode;
  logic prog_on, erase_on, susp_on, pol7;
  logic [2:0]    cur_sec, bus_sec;
  logic [AW-1:0] op_addr, raddr;
  logic          mem_we;
  logic [15:0]   mem_wdata, mem_rdata, req_word;
  logic          stat_now, stat_q, id_q, a0_q, lane_q, bm_q, tgl;

  always_comb begin
    clr      = rst || !rst_pin_n;
    wr_cond  = !ce_n && !we_n && oe_n;
    rd_cond  = !ce_n && !oe_n && we_n;
    wr_pulse = wr_cond && !wr_prev;
    bus_sec  = sec_of(TOP_BOOT, int'(addr) / UNIT_W);
    stat_now = prog_on || erase_on || (susp_on && bus_sec == cur_sec);
    raddr    = prog_on ? op_addr : addr;
    if (!byte_mode)  req_word = din;
    else if (lane)   req_word = {din[7:0], 8'hFF};
    else             req_word = {8'hFF, din[7:0]};
  end

  flc_cmd #(.AW(AW)) i_cmd (
    .clk(clk), .clr(clr), .en(ready && !susp_on), .wr_pulse(wr_pulse),
    .addr(addr), .d(din[7:0]), .req_prog(req_prog), .req_serase(req_serase),
    .req_cerase(req_cerase), .id_mode(id_mode)
  );

  flc_engine #(.TOP_BOOT(TOP_BOOT), .UNIT_W(UNIT_W), .AW(AW),
               .PROG_CYC(PROG_CYC), .STEP_CYC(STEP_CYC)) i_eng (
    .clk(clk), .clr(clr), .wr_pulse(wr_pulse), .din8(din[7:0]),
    .req_prog(req_prog), .req_serase(req_serase), .req_cerase(req_cerase),
    .req_addr(addr), .req_word(req_word), .prot(prot), .ready(ready),
    .prog_on(prog_on), .erase_on(erase_on), .susp_on(susp_on), .pol7(pol7),
    .cur_sec(cur_sec), .op_addr(op_addr), .mem_we(mem_we),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  flc_ram #(.AW(AW), .DW(16)) i_ram (
    .clk(clk), .we(mem_we), .waddr(op_addr), .wdata(mem_wdata),
    .raddr(raddr), .rdata(mem_rdata)
  );

  always_ff @(posedge clk) begin
    if (clr) begin
      wr_prev <= 1'b0; rd_prev <= 1'b0; dout_en <= 1'b0; stat_q <= 1'b0;
      id_q <= 1'b0; a0_q <= 1'b0; lane_q <= 1'b0; bm_q <= 1'b0;
      if (rst) tgl <= 1'b0;
    end else begin
      wr_prev <= wr_cond;
      rd_prev <= rd_cond;
      dout_en <= rd_cond;
      stat_q  <= stat_now;
      id_q    <= id_mode;
      a0_q    <= addr[0];
      lane_q  <= lane;
      bm_q    <= byte_mode;
      if (rd_cond && !rd_prev && stat_now) tgl <= ~tgl;
    end
  end

  always_comb begin
    if (!dout_en)   dout = '0;
    else if (stat_q) dout = {8'h00, ~pol7, tgl, 6'b0};
    else if (id_q)  dout = {8'h00, a0_q ? DEV_CODE : MFR_CODE};
    else if (bm_q)  dout = {8'h00, lane_q ? mem_rdata[15:8] : mem_rdata[7:0]};
    else            dout = mem_rdata;
  end
endmodule

// File: rtl/flc_chk.sv
module flc_chk import flc_pkg::*; #(
  parameter bit TOP_BOOT = 1'b0,
  parameter int UNIT_W   = 4,
  parameter int AW       = 7
) (
  input logic          clk,
  input logic          rst,
  input logic          rst_pin_n,
  input logic          ce_n,
  input logic          we_n,
  input logic          oe_n,
  input logic          ready,
  input logic          prog_on,
  input logic          erase_on,
  input logic [2:0]    cur_sec,
  input logic          mem_we,
  input logic [AW-1:0] mem_waddr,
  input logic [15:0]   mem_wdata,
  input logic [15:0]   mem_rdata
);
  a_r2_busy_after_write: assert property (@(posedge clk) disable iff (rst)
    $fell(ready) |-> $past(!ce_n && !we_n && oe_n));

  a_r3_clear_only: assert property (@(posedge clk) disable iff (rst)
    (prog_on && mem_we) |-> ((mem_wdata & ~mem_rdata) == 16'h0000));

  a_r4_erase_in_sector: assert property (@(posedge clk) disable iff (rst)
    (erase_on && mem_we) |-> (sec_of(TOP_BOOT, int'(mem_waddr) / UNIT_W) == cur_sec));

  a_r6_write_when_busy: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> !ready);

  a_r8_pin_abort: assert property (@(posedge clk) disable iff (rst)
    !rst_pin_n |=> ready);
endmodule

bind flash_ctrl flc_chk #(.TOP_BOOT(TOP_BOOT), .UNIT_W(UNIT_W), .AW(AW)) u_chk (
  .clk(clk), .rst(rst), .rst_pin_n(rst_pin_n), .ce_n(ce_n), .we_n(we_n),
  .oe_n(oe_n), .ready(ready), .prog_on(prog_on), .erase_on(erase_on),
  .cur_sec(cur_sec), .mem_we(mem_we), .mem_waddr(op_addr),
  .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
);

// File: tb/test_flash_ctrl.sv
module test_flash_ctrl;
  localparam int AW = 7;
  localparam int NW = 128;

  logic clk = 1'b0, rst = 1'b1, rst_pin_n = 1'b1;
  logic ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1, byte_mode = 1'b0, lane = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [15:0] din = '0;
  logic [6:0] prot = '0;
  logic [15:0] dout;
  logic dout_en, ready;

  int n_chk = 0, n_bad = 0, cyc = 0;
  logic [15:0] ref_mem [NW];

  typedef struct { logic [15:0] e; logic [15:0] m; string tag; } item_t;
  item_t sb[$];

  always #4 clk = ~clk;

  flash_ctrl i_flash_ctrl (
    .clk(clk), .rst(rst), .rst_pin_n(rst_pin_n), .ce_n(ce_n), .we_n(we_n),
    .oe_n(oe_n), .byte_mode(byte_mode), .lane(lane), .addr(addr), .din(din),
    .prot(prot), .dout(dout), .dout_en(dout_en), .ready(ready)
  );

  // monitor: every sampled read produces one result to compare
  always @(negedge clk) begin
    if (dout_en) begin
      n_chk++;
      if (sb.size() == 0) begin
        n_bad++;
        $display("FAIL unexpected read: actual %h expected none", dout);
      end else begin
        item_t it;
        it = sb.pop_front();
        if ((dout & it.m) != (it.e & it.m)) begin
          n_bad++;
          $display("FAIL %s: actual %h expected %h (mask %h)", it.tag, dout, it.e, it.m);
        end
      end
    end
  end

  task automatic check(input logic ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [15:0] d, input logic bm = 1'b0, input logic ln = 1'b0);
    @(negedge clk);
    addr = a; din = d; byte_mode = bm; lane = ln; ce_n = 1'b0; we_n = 1'b0; oe_n = 1'b1;
    @(negedge clk);
    ce_n = 1'b1; we_n = 1'b1;
  endtask

  task automatic rd(input logic [AW-1:0] a, input logic [15:0] e, input string tag,
                    input logic [15:0] m = 16'hFFFF, input logic bm = 1'b0, input logic ln = 1'b0);
    item_t it;
    @(negedge clk);
    addr = a; byte_mode = bm; lane = ln; ce_n = 1'b0; oe_n = 1'b0; we_n = 1'b1;
    it.e = e; it.m = m; it.tag = tag;
    sb.push_back(it);
    @(negedge clk);
    ce_n = 1'b1; oe_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic wait_ready(input string tag);
    int n = 0;
    while (!ready && n < 5000) begin
      @(negedge clk);
      n++;
    end
    check(ready, tag, {15'h0, ready}, 16'h0001);
  endtask

  task automatic unlock();
    wr(7'h55, 16'h00AA);
    wr(7'h2A, 16'h0055);
  endtask

  task automatic prog(input logic [AW-1:0] a, input logic [15:0] d, input logic bm = 1'b0, input logic ln = 1'b0);
    unlock();
    wr(7'h55, 16'h00A0, bm, ln);
    wr(a, d, bm, ln);
  endtask

  task automatic erase_cmd(input logic [AW-1:0] a, input logic [15:0] code);
    unlock();
    wr(7'h55, 16'h0080);
    unlock();
    wr(a, code);
  endtask

  task automatic ref_fill(input int lo, input int hi);
    for (int i = lo; i <= hi; i++) ref_mem[i] = 16'hFFFF;
  endtask

  initial begin
    while (cyc < 150000) begin
      @(posedge clk);
      cyc++;
    end
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < NW; i++) ref_mem[i] = 16'hFFFF;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1: reset state
    check(ready, "R1 ready after reset", {15'h0, ready}, 16'h0001);
    rd(0, 16'hFFFF, "R1 erased word 0");
    rd(127, 16'hFFFF, "R1 erased word 127");

    // R2 R6: program then poll status; first status read has DQ6=1
    prog(20, 16'h1234);
    check(!ready, "R2 busy after program write", {15'h0, ready}, 16'h0000);
    rd(20, 16'h00C0, "R6 status DQ7=~d7 DQ6=1");
    rd(20, 16'h0080, "R6 status DQ6 toggled");
    wait_ready("R7 program completes");
    ref_mem[20] = 16'h1234;
    rd(20, ref_mem[20], "R7 back in read mode");

    // R3: AND semantics
    prog(20, 16'hFF0F);
    wait_ready("R3 program completes");
    ref_mem[20] = ref_mem[20] & 16'hFF0F;
    rd(20, ref_mem[20], "R3 only clears bits");

    // R12: byte program high lane
    prog(21, 16'h005A, 1'b1, 1'b1);
    wait_ready("R12 byte program completes");
    ref_mem[21] = 16'h5AFF;
    rd(21, ref_mem[21], "R12 word view");
    rd(21, 16'h005A, "R12 high lane", 16'hFFFF, 1'b1, 1'b1);
    rd(21, 16'h00FF, "R12 low lane", 16'hFFFF, 1'b1, 1'b0);

    // R11: broken sequence does nothing
    wr(7'h55, 16'h00AA);
    wr(7'h10, 16'h0055);
    wr(7'h55, 16'h00A0);
    wr(22, 16'h0000);
    @(negedge clk);
    check(ready, "R11 no operation started", {15'h0, ready}, 16'h0001);
    rd(22, 16'hFFFF, "R11 word untouched");

    // neighbours for the sector-edge checks
    prog(15, 16'h0F0F); wait_ready("R13 setup 15"); ref_mem[15] = 16'h0F0F;
    prog(32, 16'h3C3C); wait_ready("R13 setup 32"); ref_mem[32] = 16'h3C3C;
    prog(31, 16'h0000); wait_ready("R13 setup 31"); ref_mem[31] = 16'h0000;

    // R5: program into protected sector 1
    prot = 7'b0000010;
    prog(8, 16'h0000);
    @(negedge clk);
    check(ready, "R5 protected program ignored", {15'h0, ready}, 16'h0001);
    rd(8, 16'hFFFF, "R5 protected word unchanged");
    prot = 7'b0000000;

    // R4 R13: erase sector 3 (words 16..31)
    erase_cmd(24, 16'h0030);
    rd(24, 16'h0000, "R6 erase status DQ7=0", 16'h0080);
    wait_ready("R4 sector erase completes");
    ref_fill(16, 31);
    rd(16, 16'hFFFF, "R13 sector 3 first word erased");
    rd(31, 16'hFFFF, "R13 sector 3 last word erased");
    rd(20, 16'hFFFF, "R4 programmed word erased");
    rd(15, ref_mem[15], "R13 word 15 outside sector kept");
    rd(32, ref_mem[32], "R13 word 32 outside sector kept");

    // R9: suspend and resume an erase of sector 6 (words 96..127)
    prog(100, 16'h0000); wait_ready("R9 setup"); ref_mem[100] = 16'h0000;
    erase_cmd(100, 16'h0030);
    repeat (40) @(negedge clk);
    wr(7'h00, 16'h00B0);
    @(negedge clk);
    check(ready, "R9 ready while suspended", {15'h0, ready}, 16'h0001);
    rd(15, ref_mem[15], "R9 read other sector in suspend");
    rd(100, 16'h0000, "R9 erasing sector shows status", 16'h0080);
    wr(7'h00, 16'h0030);
    @(negedge clk);
    check(!ready, "R9 busy after resume", {15'h0, ready}, 16'h0000);
    wait_ready("R9 resumed erase completes");
    ref_fill(96, 127);
    rd(100, 16'hFFFF, "R9 word erased after resume");
    rd(127, 16'hFFFF, "R9 last word erased");

    // R8: abort an erase of sector 5 with the reset pin
    erase_cmd(64, 16'h0030);
    repeat (20) @(negedge clk);
    rst_pin_n = 1'b0;
    @(negedge clk);
    rst_pin_n = 1'b1;
    check(ready, "R8 ready after pin reset", {15'h0, ready}, 16'h0001);
    rd(32, ref_mem[32], "R8 other sector intact");
    prog(40, 16'hA5A5);
    wait_ready("R8 program after abort");
    ref_mem[40] = 16'hA5A5;
    rd(40, ref_mem[40], "R8 commands work after abort");

    // R5: chip erase with sector 1 protected
    prog(9, 16'h0000); wait_ready("R5 setup"); ref_mem[9] = 16'h0000;
    prot = 7'b0000010;
    erase_cmd(7'h55, 16'h0010);
    wait_ready("R5 chip erase completes");
    ref_fill(0, 7); ref_fill(12, 127);
    rd(9, ref_mem[9], "R5 protected sector kept in chip erase");
    rd(15, 16'hFFFF, "R5 chip erase word 15");
    rd(40, 16'hFFFF, "R5 chip erase word 40");
    rd(70, 16'hFFFF, "R5 chip erase aborted sector");
    rd(127, 16'hFFFF, "R5 chip erase word 127");
    prot = 7'b0000000;

    // R10: ID mode
    unlock();
    wr(7'h55, 16'h0090);
    rd(0, 16'h0052, "R10 manufacturer code");
    rd(1, 16'h0057, "R10 device code");
    wr(7'h00, 16'h00F0);
    rd(9, ref_mem[9], "R10 F0 back to array");

    repeat (2) @(negedge clk);
    if (sb.size() != 0) begin
      n_chk++; n_bad++;
      $display("FAIL scoreboard: actual %0d pending expected 0", sb.size());
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule